// File: doc/BRIEF.md
# Half-rate trace nibble packer

This block sits between a processor's trace source and an external trace probe. Every processor clock cycle it receives one 4-bit trace value, which may be a status code or one nibble of an operand. It pairs consecutive values into an 8-bit output byte. Each byte stays valid for two processor cycles, so the port runs at half the processor rate.

Alongside the byte it drives a half-rate sampling clock, built as a registered toggle in the processor clock domain. The probe samples on that clock's rising edge, which falls in the middle of each two-cycle data window. The byte only changes on the clock's falling edge.

After reset the port stays silent until the first start status code arrives. A quiesce input freezes the port: the clock holds low and the byte holds its last value. Upstream logic is unaffected. When quiesce clears, the receiver must resynchronise.

Top module: `trace_packer`

## Requirements
- R1: Of the two values packed into a byte, the earlier one is placed on bits [7:4] and the later one on bits [3:0].
- R2: The output byte never changes on two consecutive clock edges; each byte is held for at least two cycles.
- R3: Pairing follows arrival order only, with no alignment to value boundaries. After the start value, value number k lands in the upper nibble when k is even and in the lower nibble when k is odd, whatever its content.
- R4: Once a byte has been emitted, the sampling clock is low in the first cycle of each data window and high in the second. Its rising edge is therefore mid-window, and the byte changes only while the clock is low.
- R5: While rst_ni is low, the byte is 0x00 and the sampling clock is low. Reset also clears the started state.
- R6: Before the started state is set, any value other than 0xC, 0xD or 0xF is ignored. The byte stays 0x00 and the sampling clock stays low.
- R7: Each of the values 0xC, 0xD and 0xF sets the started state when it arrives. The start value itself becomes the upper nibble of the first byte.
- R8: While quiesce_i is high, the sampling clock is low, the byte holds its value, and incoming values are dropped.
- R9: On the first cycle after quiesce_i falls, the incoming value begins a fresh pair in the upper nibble. The sampling clock stays low until the first new byte has been emitted. No new start value is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quiesce_i | input | 1 | Freeze the trace port and drop values |
| nib_i | input | 4 | Trace value for this cycle |
| trace_o | output | 8 | Packed trace byte, earlier value in [7:4] |
| sclk_o | output | 1 | Half-rate sampling clock for the probe |

## Verification
The bench drives nonzero values that are not start codes (0x3, 0xE) before start. A design that starts on any nonzero value would emit bytes early.

Quiesce is raised both between pairs and in the middle of a pair. A design that kept the half-built pair, or that raised the clock before the first new byte, would shift every later byte or hand the probe a stale sample.

Each start code is tried from a clean reset to catch a decoder that accepts only one of them. The clock phase is checked in every cycle of a long run to expose an inverted or off-by-one toggle.

// File: rtl/trace_pkg.sv
package trace_pkg;
  parameter int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam nib_t START_A = nib_t'(4'hC);
  localparam nib_t START_B = nib_t'(4'hD);
  localparam nib_t START_C = nib_t'(4'hF);

  function automatic logic is_start(input nib_t n);
    return (n == START_A) || (n == START_B) || (n == START_C);
  endfunction
endpackage

// File: rtl/trace_start_gate.sv
module trace_start_gate
  import trace_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic quiesce_i,
  input  nib_t nib_i,
  output logic started_o,
  output logic accept_o
);
  logic started_q;
  logic hit;

  assign hit      = !quiesce_i && is_start(nib_i);
  assign accept_o = !quiesce_i && (started_q || hit);
  assign started_o = started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  started_q <= 1'b0;
    else if (hit) started_q <= 1'b1;
  end

  // R7: started only rises on a start code seen while not quiesced
  assert_start_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q && !(is_start(nib_i) && !quiesce_i) |=> !started_q);
endmodule

// File: rtl/trace_pair.sv
module trace_pair
  import trace_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  quiesce_i,
  input  logic  accept_i,
  input  nib_t  nib_i,
  output byte_t byte_o,
  output logic  emit_o,
  output logic  mid_o
);
  logic  odd_q;
  nib_t  hi_q;
  byte_t byte_q;

  assign emit_o = accept_i &&  odd_q;
  assign mid_o  = accept_i && !odd_q;
  assign byte_o = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= 1'b0;
      hi_q   <= '0;
      byte_q <= '0;
    end else if (quiesce_i) begin
      odd_q <= 1'b0;  // partial pair dropped
    end else if (accept_i) begin
      odd_q <= ~odd_q;
      if (odd_q) byte_q <= {hi_q, nib_i};
      else       hi_q   <= nib_i;
    end
  end

  assert_hold_two_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_o |=> !emit_o);
  assert_quiesce_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiesce_i |=> $stable(byte_q));
endmodule

// File: rtl/trace_sclk_gen.sv
module trace_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic quiesce_i,
  input  logic emit_i,
  input  logic mid_i,
  output logic sclk_o
);
  logic sclk_q;
  logic live_q;  // a byte has been emitted since start or resume

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      live_q <= 1'b0;
    end else if (quiesce_i) begin
      sclk_q <= 1'b0;
      live_q <= 1'b0;
    end else if (emit_i) begin
      sclk_q <= 1'b0;
      live_q <= 1'b1;
    end else if (mid_i) begin
      sclk_q <= live_q;
    end
  end

  assign sclk_o = sclk_q;

  assert_quiesce_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiesce_i |=> !sclk_q);
  assert_fall_on_emit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |=> !sclk_q);
endmodule

// File: rtl/trace_packer.sv
module trace_packer
  import trace_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             quiesce_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [BYTE_W-1:0] trace_o,
  output logic             sclk_o
);
  logic started, accept, emit, mid;

  trace_start_gate u_gate (
    .clk_i, .rst_ni, .quiesce_i, .nib_i,
    .started_o(started), .accept_o(accept)
  );

  trace_pair u_pair (
    .clk_i, .rst_ni, .quiesce_i, .accept_i(accept), .nib_i,
    .byte_o(trace_o), .emit_o(emit), .mid_o(mid)
  );

  trace_sclk_gen u_sclk (
    .clk_i, .rst_ni, .quiesce_i, .emit_i(emit), .mid_i(mid), .sclk_o
  );

  assert_idle_before_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started |-> (!sclk_o && trace_o == '0));
  assert_change_while_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trace_o) |-> !sclk_o);
  assert_rise_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(trace_o));
endmodule

// File: tb/trace_packer_tb.sv
module trace_packer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  // {quiesce, nib, expected byte, expected sclk} per cycle, checked after the edge
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 4'h3, 8'h00, 1'b0},  // R6 ignored
    {1'b0, 4'hE, 8'h00, 1'b0},  // R6 ignored
    {1'b0, 4'h0, 8'h00, 1'b0},  // R6
    {1'b0, 4'hC, 8'h00, 1'b0},  // R7 start
    {1'b0, 4'h1, 8'hC1, 1'b0},  // R1 R7
    {1'b0, 4'h2, 8'hC1, 1'b1},  // R4 mid-window
    {1'b0, 4'h3, 8'h23, 1'b0},  // R1 R2
    {1'b0, 4'hC, 8'h23, 1'b1},  // R3 start code as data
    {1'b0, 4'h5, 8'hC5, 1'b0},  // R3
    {1'b1, 4'h9, 8'hC5, 1'b0},  // R8
    {1'b1, 4'hA, 8'hC5, 1'b0},  // R8
    {1'b0, 4'h6, 8'hC5, 1'b0},  // R9 fresh upper, clock low
    {1'b0, 4'h7, 8'h67, 1'b0},  // R9
    {1'b0, 4'h8, 8'h67, 1'b1},  // R4
    {1'b0, 4'h9, 8'h89, 1'b0},  // R1
    {1'b0, 4'hA, 8'h89, 1'b1},  // half pair
    {1'b1, 4'hB, 8'h89, 1'b0},  // R8 drops half pair
    {1'b0, 4'h4, 8'h89, 1'b0},  // R9
    {1'b0, 4'hD, 8'h4D, 1'b0},  // R9 R3
    {1'b0, 4'hF, 8'h4D, 1'b1},  // R4
    {1'b0, 4'h0, 8'hF0, 1'b0}   // R1
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       quiesce_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic [7:0] trace_o;
  logic       sclk_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_packer u_dut (.clk_i(clk), .rst_ni, .quiesce_i, .nib_i, .trace_o, .sclk_o);

  task automatic check(input string tag, input logic [7:0] eb, input logic es);
    n_chk++;
    if (trace_o !== eb || sclk_o !== es) begin
      n_bad++;
      $display("FAIL %s: byte=%h sclk=%b expected byte=%h sclk=%b", tag, trace_o, sclk_o, eb, es);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at the following negedge
  task automatic step(input logic q, input logic [3:0] n);
    quiesce_i = q;
    nib_i = n;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    quiesce_i = 1'b0;
    nib_i = 4'h0;
    @(negedge clk);
    check("R5 reset", 8'h00, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12:9]);
      check(VEC[i][13] ? "R8 vector" : "R1 R2 R3 R4 R6 R7 R9 vector", VEC[i][8:1], VEC[i][0]);
    end

    // R5: reset mid-stream clears byte, clock and started state
    rst_ni = 1'b0;
    @(negedge clk);
    check("R5 mid reset", 8'h00, 1'b0);
    rst_ni = 1'b1;
    step(1'b0, 4'h5); step(1'b0, 4'h6);
    check("R5 R6 started cleared", 8'h00, 1'b0);

    // R7: start with D
    step(1'b0, 4'hD); step(1'b0, 4'hA);
    check("R7 start D", 8'hDA, 1'b0);

    // R7: start with F, then two quiesce-free bytes check R4 phase
    do_reset();
    step(1'b0, 4'hB); step(1'b0, 4'hF); step(1'b0, 4'hF);
    check("R7 start F", 8'hFF, 1'b0);
    step(1'b0, 4'h1);
    check("R4 high mid-window", 8'hFF, 1'b1);
    step(1'b0, 4'h2);
    check("R2 R3 next byte", 8'h12, 1'b0);

    // R8: quiesce before started keeps port idle, start code under quiesce is dropped
    do_reset();
    step(1'b1, 4'hC); step(1'b0, 4'h7);
    check("R8 start dropped", 8'h00, 1'b0);
    step(1'b0, 4'hC); step(1'b0, 4'h3);
    check("R7 start C after quiesce", 8'hC3, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule